// File: doc/BRIEF.md
# Processor Sleep Entry Controller

This block decides when the processor core may stop and when it must start again. It watches three entry triggers from the core: a wait-for-interrupt strobe, a wait-for-event strobe, and an indication that an exception handler has just returned to thread mode while automatic sleep-on-return is enabled. If the trigger is accepted, it turns off the core clock enable. When deep operation is selected, it also asks the external power manager to power down the flash and to put the digital logic into retention.

Waking depends on how sleep was entered. A wait-for-interrupt sleep or an automatic sleep ends only when an interrupt is pending. A wait-for-event sleep ends when either an event or an interrupt arrives. A single-bit event latch records events that arrive while the core runs, so that a later wait-for-event returns at once. A deep sleep passes through a restore state first. There the power requests are withdrawn, and the clock stays off until the power manager acknowledges that flash and logic are usable again.

The state machine has four states. ST_RUN is the normal running state, with the clock enabled. ST_NAP is light sleep: the clock is off and no power requests are raised. ST_DEEP is deep sleep: the clock is off and both the flash-off and retention requests are high. ST_RESTORE comes after a deep sleep: the requests are low and the block waits for the acknowledge. The transitions are:
- RUN to NAP on an accepted entry with deep select low.
- RUN to DEEP on an accepted entry with deep select high.
- NAP to RUN on the wake condition.
- DEEP to RESTORE on the wake condition.
- RESTORE to RUN when the acknowledge is high.

Top module: `slp_ctrl`

## Requirements
- R1: After reset the block is in ST_RUN, with core_clk_en=1, flash_off_req=0, retain_req=0 and wake_pulse=0, and the event latch is clear. A first wfe_strobe with no event present therefore enters sleep.
- R2: In ST_RUN, a wfi_strobe while no bit of irq_pending is set drops core_clk_en on the next cycle.
- R3: In ST_RUN, a wfi_strobe while any irq_pending bit is set has no effect: core_clk_en stays 1.
- R4: In ST_RUN, a wfe_strobe while the event latch is set, or while any evt_in bit is high in the same cycle, does not enter sleep and clears the latch. A following wfe_strobe with no event then enters sleep.
- R5: A sleep entered by wfe_strobe ends on any evt_in bit or any irq_pending bit. A sleep entered by wfi_strobe or by sleep-on-return ignores evt_in and ends only on irq_pending.
- R6: In ST_RUN, a ret_to_thread pulse enters sleep only when sleep_on_ret_en=1 and no interrupt is pending. When sleep_on_ret_en=0 it has no effect.
- R7: When several entry strobes come in the same cycle, only the one with the highest priority is acted on. The order is wfi_strobe, then wfe_strobe, then ret_to_thread. A wfi_strobe that is refused because of a pending interrupt leaves the event latch untouched, even if wfe_strobe was also high.
- R8: flash_off_req and retain_req are both 1 exactly in ST_DEEP, which is entered when deep_sel=1 at the moment of entry. Light sleep raises neither request.
- R9: When the wake condition occurs in ST_DEEP, both requests drop on the next cycle while core_clk_en stays 0. The clock returns one cycle after pwr_ack is sampled high.
- R10: wake_pulse is 1 for exactly one cycle: the first ST_RUN cycle after any sleep. It is never 1 otherwise.
- R11: While not in ST_RUN, wfi_strobe, wfe_strobe and ret_to_thread are ignored.
- R12: Leaving a sleep that was entered by wait-for-event clears the event latch. The next wfe_strobe then enters sleep again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wfi_strobe | input | 1 | Wait-for-interrupt instruction executed |
| wfe_strobe | input | 1 | Wait-for-event instruction executed |
| ret_to_thread | input | 1 | Exception return to thread mode |
| sleep_on_ret_en | input | 1 | Enables sleep on return to thread mode |
| deep_sel | input | 1 | Selects deep sleep for the next entry |
| irq_pending | input | N_IRQ | Pending interrupt lines |
| evt_in | input | N_EVT | Event lines |
| pwr_ack | input | 1 | Power manager: flash and logic restored |
| core_clk_en | output | 1 | Core clock gate enable |
| flash_off_req | output | 1 | Request to power down flash |
| retain_req | output | 1 | Request to place logic in retention |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
The embedded assertions check several rules on every cycle. Power requests never overlap an enabled clock. The wake pulse never lasts more than one cycle, and it only marks a return to running. The restore state never leaves before the acknowledge. An accepted or refused wait-for-interrupt always moves, or keeps, the state as its interrupt condition dictates. Other behaviour depends on history and can only be shown by the bench scenarios, which compare every output against the reference model on every cycle. That includes how the event latch remembers earlier events, which wake source applies to which kind of entry, strobe priority when strobes collide, and strobes being ignored while asleep.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_NAP     = 2'd1,
        ST_DEEP    = 2'd2,
        ST_RESTORE = 2'd3
    } slp_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_WFI  = 2'd1,
        SRC_WFE  = 2'd2,
        SRC_EXIT = 2'd3
    } entry_src_e;

endpackage

// File: rtl/slp_evt_latch.sv
module slp_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    // clear takes precedence over a coincident event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end
    end

endmodule

// File: rtl/slp_entry_sel.sv
module slp_entry_sel
    import slp_pkg::*;
(
    input  logic wfi_i,
    input  logic wfe_i,
    input  logic ret_i,
    input  logic ret_en_i,
    input  logic irq_any_i,
    input  logic evt_any_i,
    input  logic latch_i,
    output logic go_sleep_o,
    output logic wake_on_evt_o,
    output logic consume_o
);

    entry_src_e src;

    // fixed priority: wfi over wfe over return-to-thread
    always_comb begin
        if (wfi_i) begin
            src = SRC_WFI;
        end else if (wfe_i) begin
            src = SRC_WFE;
        end else if (ret_i) begin
            src = SRC_EXIT;
        end else begin
            src = SRC_NONE;
        end
    end

    always_comb begin
        go_sleep_o    = 1'b0;
        wake_on_evt_o = 1'b0;
        consume_o     = 1'b0;
        unique case (src)
            SRC_WFI: begin
                go_sleep_o = !irq_any_i;
            end
            SRC_WFE: begin
                if (latch_i || evt_any_i) begin
                    consume_o = 1'b1;
                end else begin
                    go_sleep_o    = 1'b1;
                    wake_on_evt_o = 1'b1;
                end
            end
            SRC_EXIT: begin
                go_sleep_o = ret_en_i && !irq_any_i;
            end
            SRC_NONE: begin
                go_sleep_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_sleep_i,
    input  logic       wake_on_evt_i,
    input  logic       deep_sel_i,
    input  logic       irq_any_i,
    input  logic       evt_any_i,
    input  logic       pwr_ack_i,
    output slp_state_e state_o,
    output logic       evt_exit_o,
    output logic       core_clk_en_o,
    output logic       flash_off_req_o,
    output logic       retain_req_o,
    output logic       wake_pulse_o
);

    slp_state_e state_q;
    slp_state_e state_d;
    logic       kind_evt_q;
    logic       wake_cond;

    assign wake_cond = irq_any_i || (kind_evt_q && evt_any_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (go_sleep_i) begin
                    state_d = deep_sel_i ? ST_DEEP : ST_NAP;
                end
            end
            ST_NAP: begin
                if (wake_cond) begin
                    state_d = ST_RUN;
                end
            end
            ST_DEEP: begin
                if (wake_cond) begin
                    state_d = ST_RESTORE;
                end
            end
            ST_RESTORE: begin
                if (pwr_ack_i) begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end

    // state register, wake-source kind and wake pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_RUN;
            kind_evt_q   <= 1'b0;
            wake_pulse_o <= 1'b0;
        end else begin
            state_q      <= state_d;
            wake_pulse_o <= (state_q != ST_RUN) && (state_d == ST_RUN);
            if (state_q == ST_RUN && go_sleep_i) begin
                kind_evt_q <= wake_on_evt_i;
            end
        end
    end

    always_comb begin
        core_clk_en_o   = 1'b0;
        flash_off_req_o = 1'b0;
        retain_req_o    = 1'b0;
        unique case (state_q)
            ST_RUN:     core_clk_en_o = 1'b1;
            ST_NAP:     core_clk_en_o = 1'b0;
            ST_DEEP: begin
                flash_off_req_o = 1'b1;
                retain_req_o    = 1'b1;
            end
            ST_RESTORE: core_clk_en_o = 1'b0;
        endcase
    end

    assign evt_exit_o = kind_evt_q && wake_cond &&
                        (state_q == ST_NAP || state_q == ST_DEEP);
    assign state_o    = state_q;

    // R8
    req_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_off_req_o || retain_req_o) |-> !core_clk_en_o);

    // R9
    restore_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTORE && !pwr_ack_i) |=> (state_q == ST_RESTORE && !core_clk_en_o));

    // R10
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |=> !wake_pulse_o);

    // R10
    wake_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse_o |-> core_clk_en_o);

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int N_IRQ = 8,
    parameter int N_EVT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wfi_strobe,
    input  logic             wfe_strobe,
    input  logic             ret_to_thread,
    input  logic             sleep_on_ret_en,
    input  logic             deep_sel,
    input  logic [N_IRQ-1:0] irq_pending,
    input  logic [N_EVT-1:0] evt_in,
    input  logic             pwr_ack,
    output logic             core_clk_en,
    output logic             flash_off_req,
    output logic             retain_req,
    output logic             wake_pulse
);

    logic       irq_any;
    logic       evt_any;
    logic       latch_q;
    logic       go_raw;
    logic       wake_on_evt;
    logic       consume_raw;
    logic       evt_exit;
    logic       in_run;
    slp_state_e state;

    assign irq_any = |irq_pending;
    assign evt_any = |evt_in;
    assign in_run  = (state == ST_RUN);

    slp_entry_sel u_sel (
        .wfi_i         (wfi_strobe),
        .wfe_i         (wfe_strobe),
        .ret_i         (ret_to_thread),
        .ret_en_i      (sleep_on_ret_en),
        .irq_any_i     (irq_any),
        .evt_any_i     (evt_any),
        .latch_i       (latch_q),
        .go_sleep_o    (go_raw),
        .wake_on_evt_o (wake_on_evt),
        .consume_o     (consume_raw)
    );

    slp_evt_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt_any),
        .clr_i ((consume_raw && in_run) || evt_exit),
        .q_o   (latch_q)
    );

    slp_fsm u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .go_sleep_i      (go_raw),
        .wake_on_evt_i   (wake_on_evt),
        .deep_sel_i      (deep_sel),
        .irq_any_i       (irq_any),
        .evt_any_i       (evt_any),
        .pwr_ack_i       (pwr_ack),
        .state_o         (state),
        .evt_exit_o      (evt_exit),
        .core_clk_en_o   (core_clk_en),
        .flash_off_req_o (flash_off_req),
        .retain_req_o    (retain_req),
        .wake_pulse_o    (wake_pulse)
    );

    // R2
    wfi_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && wfi_strobe && !irq_any) |=> !core_clk_en);

    // R3
    wfi_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && wfi_strobe && irq_any) |=> core_clk_en);

    // R6
    ret_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && ret_to_thread && !wfi_strobe && !wfe_strobe && !sleep_on_ret_en)
        |=> core_clk_en);

endmodule

// File: tb/test_slp_ctrl.sv
`timescale 1ns/1ps
module test_slp_ctrl;

    localparam int NI = 4;
    localparam int NE = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wfi = 1'b0, wfe = 1'b0, ret = 1'b0, ret_en = 1'b0, deep = 1'b0, ack = 1'b0;
    logic [NI-1:0] irq = '0;
    logic [NE-1:0] evt = '0;
    logic          clk_en, fl_req, rt_req, wake;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1 reset";

    slp_ctrl #(.N_IRQ(NI), .N_EVT(NE)) i_slp_ctrl (
        .clk(clk), .rst_n(rst_n), .wfi_strobe(wfi), .wfe_strobe(wfe),
        .ret_to_thread(ret), .sleep_on_ret_en(ret_en), .deep_sel(deep),
        .irq_pending(irq), .evt_in(evt), .pwr_ack(ack),
        .core_clk_en(clk_en), .flash_off_req(fl_req), .retain_req(rt_req),
        .wake_pulse(wake)
    );

    always #2.5 clk = ~clk;

    // behavioural reference: mode 0 run, 1 light, 2 deep, 3 restoring
    int m_mode  = 0;
    bit m_latch = 0;
    bit m_byevt = 0;
    bit m_wake  = 0;

    always @(posedge clk) begin
        bit i_any, e_any, wakeup, nxt;
        i_any = |irq;
        e_any = |evt;
        if (!rst_n) begin
            m_mode = 0; m_latch = 0; m_byevt = 0; m_wake = 0;
        end else begin
            nxt    = m_latch | e_any;
            wakeup = i_any | (m_byevt & e_any);
            m_wake = 0;
            if (m_mode == 0) begin
                if (wfi) begin
                    if (!i_any) begin m_mode = deep ? 2 : 1; m_byevt = 0; end
                end else if (wfe) begin
                    if (m_latch | e_any) nxt = 0;
                    else begin m_mode = deep ? 2 : 1; m_byevt = 1; end
                end else if (ret && ret_en && !i_any) begin
                    m_mode = deep ? 2 : 1; m_byevt = 0;
                end
            end else if (m_mode == 1) begin
                if (wakeup) begin m_mode = 0; m_wake = 1; if (m_byevt) nxt = 0; end
            end else if (m_mode == 2) begin
                if (wakeup) begin m_mode = 3; if (m_byevt) nxt = 0; end
            end else begin
                if (ack) begin m_mode = 0; m_wake = 1; end
            end
            m_latch = nxt;
        end
    end

    task automatic chk(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("core_clk_en", clk_en, m_mode == 0);
            chk("flash_off_req", fl_req, m_mode == 2);
            chk("retain_req", rt_req, m_mode == 2);
            chk("wake_pulse", wake, m_wake);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulse_wfi(); wfi = 1'b1; cyc(1); wfi = 1'b0; endtask
    task automatic pulse_wfe(); wfe = 1'b1; cyc(1); wfe = 1'b0; endtask
    task automatic pulse_evt(); evt = 2'b10; cyc(1); evt = '0; endtask
    task automatic pulse_irq(); irq = 4'b0100; cyc(1); irq = '0; endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        cur_req = "R1 reset state";
        chk("R1 clk_en after reset", clk_en, 1'b1);
        chk("R1 flash req after reset", fl_req, 1'b0);

        cur_req = "R1 latch clear: first WFE sleeps";
        pulse_wfe(); cyc(2);
        chk("R1 asleep", clk_en, 1'b0);
        pulse_irq(); cyc(2);

        cur_req = "R2 WFI sleep and R10 wake pulse";
        pulse_wfi(); cyc(3);
        pulse_irq(); cyc(3);

        cur_req = "R3 WFI with pending irq";
        irq = 4'b0001; pulse_wfi(); cyc(2); irq = '0; cyc(1);

        cur_req = "R4 WFE with latched event";
        pulse_evt(); cyc(1); pulse_wfe(); cyc(2);
        chk("R4 no sleep", clk_en, 1'b1);
        cur_req = "R4 second WFE sleeps";
        pulse_wfe(); cyc(2);
        cur_req = "R5 R12 WFE sleep woken by event";
        pulse_evt(); cyc(2);
        cur_req = "R12 latch consumed: WFE sleeps again";
        pulse_wfe(); cyc(2);
        chk("R12 asleep", clk_en, 1'b0);
        cur_req = "R5 WFE sleep woken by irq";
        pulse_irq(); cyc(2);

        cur_req = "R4 WFE with same-cycle event";
        evt = 2'b01; pulse_wfe(); evt = '0; cyc(2);

        cur_req = "R5 WFI sleep ignores events";
        pulse_wfi(); cyc(1); pulse_evt(); cyc(3);
        chk("R5 still asleep", clk_en, 1'b0);
        cur_req = "R11 strobes ignored while asleep";
        pulse_wfe(); ret = 1'b1; ret_en = 1'b1; cyc(1); ret = 1'b0; pulse_wfi(); cyc(2);
        pulse_irq(); cyc(2);

        cur_req = "R6 return with sleep-on-return disabled";
        ret_en = 1'b0; ret = 1'b1; cyc(1); ret = 1'b0; cyc(2);
        cur_req = "R6 return with sleep-on-return enabled";
        ret_en = 1'b1; ret = 1'b1; cyc(1); ret = 1'b0; cyc(2);
        pulse_irq(); cyc(2);
        cur_req = "R6 return with pending irq";
        irq = 4'b1000; ret = 1'b1; cyc(1); ret = 1'b0; irq = '0; cyc(2);
        ret_en = 1'b0;

        cur_req = "R7 priority wfi over wfe keeps latch";
        pulse_evt(); cyc(1);
        irq = 4'b0010; wfi = 1'b1; wfe = 1'b1; cyc(1); wfi = 1'b0; wfe = 1'b0; irq = '0; cyc(1);
        pulse_wfe(); cyc(2);
        chk("R7 latch survived", clk_en, 1'b1);
        cur_req = "R7 wfe over return";
        ret_en = 1'b1; wfe = 1'b1; ret = 1'b1; cyc(1); wfe = 1'b0; ret = 1'b0; ret_en = 1'b0; cyc(1);
        pulse_evt(); cyc(2);

        cur_req = "R8 deep sleep requests";
        deep = 1'b1; pulse_wfi(); cyc(3);
        chk("R8 flash req", fl_req, 1'b1);
        cur_req = "R9 restore waits for ack";
        pulse_irq(); cyc(4);
        chk("R9 clock held off", clk_en, 1'b0);
        ack = 1'b1; cyc(1); ack = 1'b0; cyc(3);

        cur_req = "R12 deep WFE woken by event";
        pulse_wfe(); cyc(2); pulse_evt(); cyc(2); ack = 1'b1; cyc(1); ack = 1'b0; cyc(2);
        pulse_wfe(); cyc(2);
        chk("R12 deep asleep again", fl_req, 1'b1);
        pulse_irq(); cyc(1); ack = 1'b1; cyc(1); ack = 1'b0; deep = 1'b0; cyc(3);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule